// File: doc/BRIEF.md
# Direct-Mapped Address Translation Cache

This block caches completed page-table translations for a 39-bit virtual address space with three 9-bit page-number levels above a 4 KiB page offset. It holds 64 slots and is direct-mapped: the six page-number bits just above the page offset pick one slot. A fill from the page walker writes that slot and replaces whatever it held. A lookup examines only that slot and answers in the same cycle. The answer is a hit flag, the slot number, the composed physical address, the stored page-table entry and the physical address of that entry.

A separate write-back port rewrites the page-table-entry bits of a named slot in place, for example after the accessed or dirty bits change. A flush request takes an optional address-space ID and an optional virtual page number. A small sequencer then visits every slot, one per cycle, and invalidates each valid slot that meets the criteria.

The sequencer has three named states. SCN_IDLE waits for a request. SCN_WALK scans one slot per cycle. SCN_DONE raises the completion pulse. Its transitions are:
- start: SCN_IDLE to SCN_WALK when `fl_req` is high.
- last-slot: SCN_WALK to SCN_DONE once the final slot is scanned.
- return: SCN_DONE to SCN_IDLE unconditionally.

A reset or a one-cycle `init_i` pulse invalidates every slot.

Top module: `xlt_dm_cache`

## Requirements
- R1: After reset, and in the cycle after `init_i` is high at a clock edge, every slot is invalid: every lookup misses and `fl_busy`, `fl_done` are low after reset.
- R2: The slot used by both lookup and fill is virtual address bits [17:12] (for fill, `fill_vpn[5:0]`), read as an unsigned number 0..63. `lk_index` always reports the slot a lookup selected.
- R3: A lookup hits only when the selected slot is valid, its page number matches, and either the slot is global or its stored address-space ID equals `lk_asid`.
- R4: Level encoding: 0 = 4 KiB page, 1 = 2 MiB page, 2 or 3 = 1 GiB page. The page-number compare uses only the 9-bit groups at and above the level: bits [38:12], [38:21] or [38:30] respectively.
- R5: On a hit, `lk_paddr` takes the stored physical address above the page offset and `lk_vaddr` within it; the offset is 12, 21 or 30 bits for levels 0, 1, 2/3. On a miss, `lk_paddr`, `lk_pte` and `lk_pte_addr` are zero.
- R6: A fill writes all fields of its slot and makes it valid, replacing any previous translation there, and touches no other slot.
- R7: A write-back replaces only the page-table-entry bits of slot `wb_index`. Validity, tag, physical address and entry address stay as they were.
- R8: A flush request accepted in SCN_IDLE makes `fl_busy` high for exactly 64 cycles, then `fl_done` high for one cycle. A request while busy or done is ignored and starts nothing.
- R9: A flush with neither criterion invalidates every slot.
- R10: A flush with only the address-space ID invalidates the non-global slots holding that ID and spares global slots.
- R11: A flush with only the page number invalidates every slot, global or not, whose page covers that page number at its own level.
- R12: A flush with both criteria invalidates only non-global slots holding that ID that also cover that page number.
- R13: A lookup in the same cycle as a fill to its slot returns the slot's previous contents; the new translation is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Invalidate all slots at this edge |
| lk_asid | input | 16 | Lookup address-space ID |
| lk_vaddr | input | 39 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_index | output | 6 | Slot selected by the lookup |
| lk_paddr | output | 56 | Translated physical address (zero on miss) |
| lk_pte | output | 64 | Stored page-table entry (zero on miss) |
| lk_pte_addr | output | 56 | Physical address of the stored entry (zero on miss) |
| fill_valid | input | 1 | Install a translation at this edge |
| fill_asid | input | 16 | Address-space ID of the new translation |
| fill_global | input | 1 | New translation is global |
| fill_vpn | input | 27 | Virtual page number (address bits [38:12]) |
| fill_paddr | input | 56 | Physical address produced by the walk |
| fill_pte | input | 64 | Leaf page-table entry |
| fill_level | input | 2 | Leaf level |
| fill_pte_addr | input | 56 | Physical address of the leaf entry |
| wb_valid | input | 1 | Rewrite an entry's page-table bits at this edge |
| wb_index | input | 6 | Slot to rewrite |
| wb_pte | input | 64 | New page-table-entry bits |
| fl_req | input | 1 | Start a flush |
| fl_use_asid | input | 1 | Flush is limited to an address-space ID |
| fl_asid | input | 16 | Address-space ID for the flush |
| fl_use_addr | input | 1 | Flush is limited to a page number |
| fl_vpn | input | 27 | Page number for the flush |
| fl_busy | output | 1 | Flush scan in progress |
| fl_done | output | 1 | One-cycle flush completion pulse |

## Verification
The bench targets large pages probed at offsets far from the filling address. A design that compared all page-number bits would miss there, and one that masked the wrong bits would hand back a corrupt physical address. It runs each flush flavour against a mix of global and non-global slots. A design that let the ID-based or combined flush clear global slots, or let the address-only flush spare them, shows as a wrong hit after the flush. It also counts busy cycles and pokes a second request mid-scan, so a scanner that is off by one or restarts shows up. Same-cycle fill-and-lookup, overwriting of a shared slot and write-back catch a cache that forwards writes combinationally, keeps two translations per slot or lets a write-back disturb the tag.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    parameter int ASID_W   = 16;
    parameter int VA_W     = 39;
    parameter int PA_W     = 56;
    parameter int PTE_W    = 64;
    parameter int LVL_W    = 2;
    parameter int PG_SHIFT = 12;
    parameter int SEG_W    = 9;

    localparam int VPN_W   = VA_W - PG_SHIFT;
    localparam int NUM_SEG = VPN_W / SEG_W;

    // one cached translation; validity is kept outside the struct
    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic              glb;
        logic [VPN_W-1:0]  vpn;
        logic [PA_W-1:0]   pa;
        logic [PTE_W-1:0]  pte;
        logic [LVL_W-1:0]  lvl;
        logic [PA_W-1:0]   pte_pa;
    } slot_t;

    typedef enum logic [1:0] {
        SCN_IDLE = 2'd0,
        SCN_WALK = 2'd1,
        SCN_DONE = 2'd2
    } scan_st_e;

    // mask of the untranslated offset bits for a leaf level; levels past the
    // top segment are treated as the top segment
    function automatic logic [PA_W-1:0] off_mask(input logic [LVL_W-1:0] lvl);
        int eff;
        int sh;
        eff = (int'(lvl) > NUM_SEG - 1) ? (NUM_SEG - 1) : int'(lvl);
        sh  = PG_SHIFT + SEG_W * eff;
        return ({{(PA_W-1){1'b0}}, 1'b1} << sh) - {{(PA_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/xlt_vpn_cmp.sv
module xlt_vpn_cmp
    import xlt_pkg::*;
(
    input  logic [VPN_W-1:0] tag_vpn,
    input  logic [LVL_W-1:0] lvl,
    input  logic [VPN_W-1:0] probe_vpn,
    output logic             covers
);

    logic [NUM_SEG-1:0] seg_eq;
    logic [NUM_SEG-1:0] seg_need;

    // segment s is compared when it lies at or above the leaf level;
    // the topmost segment is always compared
    generate
        for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
            assign seg_eq[s]   = (tag_vpn[s*SEG_W +: SEG_W] == probe_vpn[s*SEG_W +: SEG_W]);
            assign seg_need[s] = (s == NUM_SEG - 1) || (int'(lvl) <= s);
        end
    endgenerate

    assign covers = &(seg_eq | ~seg_need);

endmodule

// File: rtl/xlt_scan_fsm.sv
module xlt_scan_fsm
    import xlt_pkg::*;
#(
    parameter  int NUM_ENTRIES = 64,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              use_asid,
    input  logic [ASID_W-1:0] asid,
    input  logic              use_vpn,
    input  logic [VPN_W-1:0]  vpn,
    output logic              busy,
    output logic              done,
    output logic              scan_en,
    output logic [IDX_W-1:0]  scan_idx,
    output logic              crit_use_asid,
    output logic [ASID_W-1:0] crit_asid,
    output logic              crit_use_vpn,
    output logic [VPN_W-1:0]  crit_vpn
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    scan_st_e          st_q;
    scan_st_e          st_d;
    logic [IDX_W-1:0]  ptr_q;
    logic              c_use_asid_q;
    logic [ASID_W-1:0] c_asid_q;
    logic              c_use_vpn_q;
    logic [VPN_W-1:0]  c_vpn_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SCN_IDLE: if (req) st_d = SCN_WALK;              // start
            SCN_WALK: if (ptr_q == LAST_IDX) st_d = SCN_DONE; // last-slot
            SCN_DONE: st_d = SCN_IDLE;                        // return
            default:  st_d = SCN_IDLE;
        endcase
    end

    // state register, scan pointer and latched criteria
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= SCN_IDLE;
            ptr_q        <= '0;
            c_use_asid_q <= 1'b0;
            c_asid_q     <= '0;
            c_use_vpn_q  <= 1'b0;
            c_vpn_q      <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == SCN_IDLE && req) begin
                ptr_q        <= '0;
                c_use_asid_q <= use_asid;
                c_asid_q     <= asid;
                c_use_vpn_q  <= use_vpn;
                c_vpn_q      <= vpn;
            end else if (st_q == SCN_WALK) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy          = (st_q == SCN_WALK);
        done          = (st_q == SCN_DONE);
        scan_en       = (st_q == SCN_WALK);
        scan_idx      = ptr_q;
        crit_use_asid = c_use_asid_q;
        crit_asid     = c_asid_q;
        crit_use_vpn  = c_use_vpn_q;
        crit_vpn      = c_vpn_q;
    end

    // R8: the scan pointer advances by exactly one slot per walking cycle
    p_walk_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SCN_WALK && ptr_q != LAST_IDX) |=> (st_q == SCN_WALK && ptr_q == $past(ptr_q) + 1'b1));

    // R8: completion is a single-cycle pulse followed by idle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R8: an accepted request begins at slot zero
    p_start_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SCN_IDLE && req) |=> (busy && scan_idx == '0));

endmodule

// File: rtl/xlt_slot_store.sv
module xlt_slot_store
    import xlt_pkg::*;
#(
    parameter  int NUM_ENTRIES = 64,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  slot_t             fill_slot,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [PTE_W-1:0]  wb_pte,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic              ra_valid,
    output slot_t             ra_slot,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic              rb_valid,
    output logic [ASID_W-1:0] rb_asid,
    output logic              rb_glb,
    output logic [VPN_W-1:0]  rb_vpn,
    output logic [LVL_W-1:0]  rb_lvl
);

    logic [NUM_ENTRIES-1:0] vld_q;
    slot_t                  slot_q [NUM_ENTRIES];

    generate
        for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(e);
            logic  fill_me;
            logic  wb_me;
            logic  clr_me;
            logic  vld_r;
            slot_t data_r;

            assign fill_me = fill_en && (fill_idx == MY_IDX);
            assign wb_me   = wb_en   && (wb_idx   == MY_IDX);
            assign clr_me  = clr_en  && (clr_idx  == MY_IDX);

            // init beats fill, fill beats a flush clear of the same slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_r <= 1'b0;
                end else if (init) begin
                    vld_r <= 1'b0;
                end else if (fill_me) begin
                    vld_r <= 1'b1;
                end else if (clr_me) begin
                    vld_r <= 1'b0;
                end
            end

            // payload has no reset: it is never observed while invalid
            always_ff @(posedge clk) begin
                if (fill_me) begin
                    data_r <= fill_slot;
                end else if (wb_me) begin
                    data_r.pte <= wb_pte;
                end
            end

            assign vld_q[e]  = vld_r;
            assign slot_q[e] = data_r;
        end
    endgenerate

    always_comb begin
        ra_valid = vld_q[ra_idx];
        ra_slot  = slot_q[ra_idx];
        rb_valid = vld_q[rb_idx];
        rb_asid  = slot_q[rb_idx].asid;
        rb_glb   = slot_q[rb_idx].glb;
        rb_vpn   = slot_q[rb_idx].vpn;
        rb_lvl   = slot_q[rb_idx].lvl;
    end

    // R6: a fill (without init) always leaves its slot valid
    p_fill_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !init) |=> vld_q[$past(fill_idx)]);

    // R9: a flush clear that no fill contends with empties the slot
    p_clr_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !init && !(fill_en && fill_idx == clr_idx)) |=> !vld_q[$past(clr_idx)]);

endmodule

// File: rtl/xlt_dm_cache.sv
module xlt_dm_cache
    import xlt_pkg::*;
#(
    parameter  int NUM_ENTRIES = 64,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_index,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [PTE_W-1:0]  lk_pte,
    output logic [PA_W-1:0]   lk_pte_addr,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PA_W-1:0]   fill_paddr,
    input  logic [PTE_W-1:0]  fill_pte,
    input  logic [LVL_W-1:0]  fill_level,
    input  logic [PA_W-1:0]   fill_pte_addr,
    input  logic              wb_valid,
    input  logic [IDX_W-1:0]  wb_index,
    input  logic [PTE_W-1:0]  wb_pte,
    input  logic              fl_req,
    input  logic              fl_use_asid,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic              fl_use_addr,
    input  logic [VPN_W-1:0]  fl_vpn,
    output logic              fl_busy,
    output logic              fl_done
);

    // lookup side
    logic [IDX_W-1:0] lk_idx;
    logic [VPN_W-1:0] lk_vpn;
    logic             ra_valid;
    slot_t            ra_slot;
    logic             lk_covers;
    logic [PA_W-1:0]  lk_mask;
    logic [PA_W-1:0]  lk_va_ext;

    // fill side
    logic [IDX_W-1:0] fill_idx;
    slot_t            fill_slot;

    // flush side
    logic              scan_en;
    logic [IDX_W-1:0]  scan_idx;
    logic              crit_use_asid;
    logic [ASID_W-1:0] crit_asid;
    logic              crit_use_vpn;
    logic [VPN_W-1:0]  crit_vpn;
    logic              rb_valid;
    logic [ASID_W-1:0] rb_asid;
    logic              rb_glb;
    logic [VPN_W-1:0]  rb_vpn;
    logic [LVL_W-1:0]  rb_lvl;
    logic              fl_covers;
    logic              fl_match;
    logic              clr_en;

    assign lk_vpn   = lk_vaddr[VA_W-1:PG_SHIFT];
    assign lk_idx   = lk_vpn[IDX_W-1:0];
    assign fill_idx = fill_vpn[IDX_W-1:0];

    always_comb begin
        fill_slot.asid   = fill_asid;
        fill_slot.glb    = fill_global;
        fill_slot.vpn    = fill_vpn;
        fill_slot.pa     = fill_paddr;
        fill_slot.pte    = fill_pte;
        fill_slot.lvl    = fill_level;
        fill_slot.pte_pa = fill_pte_addr;
    end

    xlt_slot_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (init_i),
        .fill_en   (fill_valid),
        .fill_idx  (fill_idx),
        .fill_slot (fill_slot),
        .wb_en     (wb_valid),
        .wb_idx    (wb_index),
        .wb_pte    (wb_pte),
        .clr_en    (clr_en),
        .clr_idx   (scan_idx),
        .ra_idx    (lk_idx),
        .ra_valid  (ra_valid),
        .ra_slot   (ra_slot),
        .rb_idx    (scan_idx),
        .rb_valid  (rb_valid),
        .rb_asid   (rb_asid),
        .rb_glb    (rb_glb),
        .rb_vpn    (rb_vpn),
        .rb_lvl    (rb_lvl)
    );

    xlt_vpn_cmp u_lk_cmp (
        .tag_vpn   (ra_slot.vpn),
        .lvl       (ra_slot.lvl),
        .probe_vpn (lk_vpn),
        .covers    (lk_covers)
    );

    always_comb begin
        lk_mask   = off_mask(ra_slot.lvl);
        lk_va_ext = {{(PA_W-VA_W){1'b0}}, lk_vaddr};
        lk_hit    = ra_valid && lk_covers && (ra_slot.glb || (ra_slot.asid == lk_asid));
        lk_index  = lk_idx;
        if (lk_hit) begin
            lk_paddr    = (ra_slot.pa & ~lk_mask) | (lk_va_ext & lk_mask);
            lk_pte      = ra_slot.pte;
            lk_pte_addr = ra_slot.pte_pa;
        end else begin
            lk_paddr    = '0;
            lk_pte      = '0;
            lk_pte_addr = '0;
        end
    end

    xlt_scan_fsm #(.NUM_ENTRIES(NUM_ENTRIES)) u_scan (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (fl_req),
        .use_asid      (fl_use_asid),
        .asid          (fl_asid),
        .use_vpn       (fl_use_addr),
        .vpn           (fl_vpn),
        .busy          (fl_busy),
        .done          (fl_done),
        .scan_en       (scan_en),
        .scan_idx      (scan_idx),
        .crit_use_asid (crit_use_asid),
        .crit_asid     (crit_asid),
        .crit_use_vpn  (crit_use_vpn),
        .crit_vpn      (crit_vpn)
    );

    xlt_vpn_cmp u_fl_cmp (
        .tag_vpn   (rb_vpn),
        .lvl       (rb_lvl),
        .probe_vpn (crit_vpn),
        .covers    (fl_covers)
    );

    // an ID criterion never selects a global slot; a page criterion needs coverage
    always_comb begin
        fl_match = (!crit_use_asid || (!rb_glb && (rb_asid == crit_asid)))
                && (!crit_use_vpn  || fl_covers);
        clr_en   = scan_en && rb_valid && fl_match;
    end

    // R1: nothing can hit in the cycle after an init
    p_init_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> !lk_hit);

    // R8: busy and done never overlap
    p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_busy && fl_done));

    // R7: a write-back alone does not turn a held hit into a miss
    p_wb_keeps_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !fill_valid && !init_i && !fl_busy && lk_hit)
        |=> (lk_vaddr != $past(lk_vaddr) || lk_asid != $past(lk_asid) || lk_hit));

endmodule

// File: tb/xlt_dm_cache_tb_top.sv
module xlt_dm_cache_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    localparam logic [1:0] OP_FILL  = 2'd0;
    localparam logic [1:0] OP_LOOK  = 2'd1;
    localparam logic [1:0] OP_FLUSH = 2'd2;

    typedef struct packed {
        logic [7:0]  rq;
        logic [1:0]  op;
        logic [15:0] asid;
        logic [38:0] va;
        logic        glb;
        logic [1:0]  lvl;
        logic [55:0] pa;
        logic        ua;
        logic        uv;
        logic        eh;
        logic [55:0] epa;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VT [NV] = '{
        '{8'd6,  OP_FILL,  16'd1, 39'h00_1234_5000, 1'b0, 2'd0, 56'h0_ABCD_E000, 1'b0, 1'b0, 1'b0, 56'h0},           // R6
        '{8'd5,  OP_LOOK,  16'd1, 39'h00_1234_5678, 1'b0, 2'd0, 56'h0, 1'b0, 1'b0, 1'b1, 56'h0_ABCD_E678},           // R5
        '{8'd3,  OP_LOOK,  16'd2, 39'h00_1234_5678, 1'b0, 2'd0, 56'h0, 1'b0, 1'b0, 1'b0, 56'h0},                     // R3 asid mismatch
        '{8'd4,  OP_LOOK,  16'd1, 39'h00_5234_5678, 1'b0, 2'd0, 56'h0, 1'b0, 1'b0, 1'b0, 56'h0},                     // R4 vpn mismatch
        '{8'd6,  OP_FILL,  16'd7, 39'h40_0020_3000, 1'b1, 2'd2, 56'h1_4020_3000, 1'b0, 1'b0, 1'b0, 56'h0},           // R6 global 1G
        '{8'd3,  OP_LOOK,  16'd9, 39'h40_0020_3ABC, 1'b0, 2'd0, 56'h0, 1'b0, 1'b0, 1'b1, 56'h1_4020_3ABC},           // R3 global ignores asid
        '{8'd4,  OP_LOOK,  16'd9, 39'h40_1FC0_3010, 1'b0, 2'd0, 56'h0, 1'b0, 1'b0, 1'b1, 56'h1_5FC0_3010},           // R4 1G offset
        '{8'd6,  OP_FILL,  16'd3, 39'h00_0060_1000, 1'b0, 2'd1, 56'h0_0A00_1000, 1'b0, 1'b0, 1'b0, 56'h0},           // R6 2M
        '{8'd4,  OP_LOOK,  16'd3, 39'h00_0064_1234, 1'b0, 2'd0, 56'h0, 1'b0, 1'b0, 1'b1, 56'h0_0A04_1234},           // R4 2M offset
        '{8'd4,  OP_LOOK,  16'd3, 39'h00_0084_1000, 1'b0, 2'd0, 56'h0, 1'b0, 1'b0, 1'b0, 56'h0},                     // R4 other 2M page
        '{8'd10, OP_FLUSH, 16'd7, 39'h0, 1'b0, 2'd0, 56'h0, 1'b1, 1'b0, 1'b0, 56'h0},                                // R10
        '{8'd10, OP_LOOK,  16'd9, 39'h40_0020_3ABC, 1'b0, 2'd0, 56'h0, 1'b0, 1'b0, 1'b1, 56'h1_4020_3ABC},           // R10 global spared
        '{8'd10, OP_FLUSH, 16'd1, 39'h0, 1'b0, 2'd0, 56'h0, 1'b1, 1'b0, 1'b0, 56'h0},                                // R10
        '{8'd10, OP_LOOK,  16'd1, 39'h00_1234_5678, 1'b0, 2'd0, 56'h0, 1'b0, 1'b0, 1'b0, 56'h0},                     // R10 cleared
        '{8'd10, OP_LOOK,  16'd3, 39'h00_0064_1234, 1'b0, 2'd0, 56'h0, 1'b0, 1'b0, 1'b1, 56'h0_0A04_1234},           // R10 other id kept
        '{8'd11, OP_FLUSH, 16'd0, 39'h40_0000_0000, 1'b0, 2'd0, 56'h0, 1'b0, 1'b1, 1'b0, 56'h0},                     // R11
        '{8'd11, OP_LOOK,  16'd9, 39'h40_0020_3ABC, 1'b0, 2'd0, 56'h0, 1'b0, 1'b0, 1'b0, 56'h0},                     // R11 global cleared
        '{8'd11, OP_LOOK,  16'd3, 39'h00_0064_1234, 1'b0, 2'd0, 56'h0, 1'b0, 1'b0, 1'b1, 56'h0_0A04_1234},           // R11 not covered
        '{8'd9,  OP_FLUSH, 16'd0, 39'h0, 1'b0, 2'd0, 56'h0, 1'b0, 1'b0, 1'b0, 56'h0},                                // R9
        '{8'd9,  OP_LOOK,  16'd3, 39'h00_0064_1234, 1'b0, 2'd0, 56'h0, 1'b0, 1'b0, 1'b0, 56'h0}                      // R9 all gone
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0;
    logic [15:0] lk_asid = '0;
    logic [38:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [5:0]  lk_index;
    logic [55:0] lk_paddr;
    logic [63:0] lk_pte;
    logic [55:0] lk_pte_addr;
    logic        fill_valid = 1'b0;
    logic [15:0] fill_asid = '0;
    logic        fill_global = 1'b0;
    logic [26:0] fill_vpn = '0;
    logic [55:0] fill_paddr = '0;
    logic [63:0] fill_pte = '0;
    logic [1:0]  fill_level = '0;
    logic [55:0] fill_pte_addr = '0;
    logic        wb_valid = 1'b0;
    logic [5:0]  wb_index = '0;
    logic [63:0] wb_pte = '0;
    logic        fl_req = 1'b0;
    logic        fl_use_asid = 1'b0;
    logic [15:0] fl_asid = '0;
    logic        fl_use_addr = 1'b0;
    logic [26:0] fl_vpn = '0;
    logic        fl_busy;
    logic        fl_done;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlt_dm_cache dut_i (
        .clk(clk), .rst_n(rst_n), .init_i(init_i),
        .lk_asid(lk_asid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_index(lk_index),
        .lk_paddr(lk_paddr), .lk_pte(lk_pte), .lk_pte_addr(lk_pte_addr),
        .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_global(fill_global),
        .fill_vpn(fill_vpn), .fill_paddr(fill_paddr), .fill_pte(fill_pte),
        .fill_level(fill_level), .fill_pte_addr(fill_pte_addr),
        .wb_valid(wb_valid), .wb_index(wb_index), .wb_pte(wb_pte),
        .fl_req(fl_req), .fl_use_asid(fl_use_asid), .fl_asid(fl_asid),
        .fl_use_addr(fl_use_addr), .fl_vpn(fl_vpn), .fl_busy(fl_busy), .fl_done(fl_done)
    );

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic do_fill(input logic [15:0] a, input logic [38:0] va, input logic g,
                           input logic [1:0] lv, input logic [55:0] pa);
        fill_valid = 1'b1; fill_asid = a; fill_global = g; fill_vpn = va[38:12];
        fill_paddr = pa; fill_pte = {8'h5A, pa}; fill_level = lv; fill_pte_addr = pa ^ 56'hF0F0;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic look(input logic [15:0] a, input logic [38:0] va);
        lk_asid = a; lk_vaddr = va;
        #1;
    endtask

    task automatic wipe();
        init_i = 1'b1;
        @(negedge clk);
        init_i = 1'b0;
    endtask

    task automatic do_flush(input logic ua, input logic [15:0] a, input logic uv,
                            input logic [38:0] va, input bit poke);
        int cnt;
        fl_req = 1'b1; fl_use_asid = ua; fl_asid = a; fl_use_addr = uv; fl_vpn = va[38:12];
        @(negedge clk);
        fl_req = 1'b0;
        cnt = 0;
        while (fl_busy === 1'b1 && cnt < 100) begin
            cnt++;
            fl_req = poke && (cnt == 10);
            @(negedge clk);
            fl_req = 1'b0;
        end
        chk("R8", "busy cycles", 64'(cnt), 64'd64);
        chk("R8", "done pulse", 64'(fl_done), 64'd1);
        @(negedge clk);
        chk("R8", "idle after done", {62'd0, fl_busy, fl_done}, 64'd0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "busy/done after reset", {62'd0, fl_busy, fl_done}, 64'd0);
        look(16'd1, 39'h00_1234_5678);
        chk("R1", "miss after reset", 64'(lk_hit), 64'd0);
        look(16'd0, 39'h00_0000_0000);
        chk("R1", "miss slot0 after reset", 64'(lk_hit), 64'd0);
        chk("R5", "paddr zero on miss", 64'(lk_paddr), 64'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VT[i].rq);
            unique case (VT[i].op)
                OP_FILL:  do_fill(VT[i].asid, VT[i].va, VT[i].glb, VT[i].lvl, VT[i].pa);
                OP_FLUSH: do_flush(VT[i].ua, VT[i].asid, VT[i].uv, VT[i].va, 1'b0);
                default: begin
                    look(VT[i].asid, VT[i].va);
                    chk(tag, $sformatf("vec%0d hit", i), 64'(lk_hit), 64'(VT[i].eh));
                    if (VT[i].eh) begin
                        chk(tag, $sformatf("vec%0d paddr", i), 64'(lk_paddr), 64'(VT[i].epa));
                        chk("R2", $sformatf("vec%0d index", i), 64'(lk_index), 64'(VT[i].va[17:12]));
                    end
                    @(negedge clk);
                end
            endcase
        end

        // R2 / R6: two pages sharing slot 5; the later fill replaces the earlier
        wipe();
        do_fill(16'd2, 39'h00_0010_5000, 1'b0, 2'd0, 56'h0_3333_3000);
        do_fill(16'd2, 39'h00_0030_5000, 1'b0, 2'd0, 56'h0_4444_4000);
        look(16'd2, 39'h00_0010_5010);
        chk("R6", "overwritten page misses", 64'(lk_hit), 64'd0);
        chk("R2", "index from bits 17:12", 64'(lk_index), 64'd5);
        look(16'd2, 39'h00_0030_5010);
        chk("R6", "new page hits", 64'(lk_hit), 64'd1);
        chk("R6", "new page pte", lk_pte, {8'h5A, 56'h0_4444_4000});
        chk("R6", "new pte address", 64'(lk_pte_addr), 64'(56'h0_4444_4000 ^ 56'hF0F0));
        @(negedge clk);

        // R7: write-back changes only the entry bits
        wb_valid = 1'b1; wb_index = 6'd5; wb_pte = 64'hDEAD_BEEF_0000_1111;
        @(negedge clk);
        wb_valid = 1'b0;
        look(16'd2, 39'h00_0030_5ABC);
        chk("R7", "hit kept after write-back", 64'(lk_hit), 64'd1);
        chk("R7", "pte replaced", lk_pte, 64'hDEAD_BEEF_0000_1111);
        chk("R7", "paddr kept", 64'(lk_paddr), 64'h0_4444_4ABC);
        wb_valid = 1'b1; wb_index = 6'd6; wb_pte = 64'h1;
        @(negedge clk);
        wb_valid = 1'b0;
        look(16'd2, 39'h00_0030_6000);
        chk("R7", "write-back leaves empty slot invalid", 64'(lk_hit), 64'd0);
        @(negedge clk);

        // R1: init clears everything
        wipe();
        look(16'd2, 39'h00_0030_5ABC);
        chk("R1", "miss after init", 64'(lk_hit), 64'd0);

        // R12: both criteria; global slot of the same id and uncovered slot survive
        do_fill(16'd4, 39'h00_0000_8000, 1'b1, 2'd0, 56'h0_0001_0000);
        do_fill(16'd4, 39'h00_0000_9000, 1'b0, 2'd0, 56'h0_0002_0000);
        do_fill(16'd4, 39'h00_0000_A000, 1'b0, 2'd0, 56'h0_0003_0000);
        do_flush(1'b1, 16'd4, 1'b1, 39'h00_0000_9000, 1'b0);
        do_flush(1'b1, 16'd4, 1'b1, 39'h00_0000_8000, 1'b0);
        look(16'd4, 39'h00_0000_9000);
        chk("R12", "matching non-global cleared", 64'(lk_hit), 64'd0);
        look(16'd4, 39'h00_0000_8004);
        chk("R12", "global spared", 64'(lk_hit), 64'd1);
        look(16'd4, 39'h00_0000_A000);
        chk("R12", "uncovered spared", 64'(lk_hit), 64'd1);

        // R8: a request during the scan is ignored
        do_flush(1'b0, 16'd0, 1'b0, 39'h0, 1'b1);
        look(16'd4, 39'h00_0000_8004);
        chk("R8", "flush-all completed", 64'(lk_hit), 64'd0);

        // R13: lookup in the fill cycle sees the old slot
        fill_valid = 1'b1; fill_asid = 16'd8; fill_global = 1'b0; fill_vpn = 27'h000_0011;
        fill_paddr = 56'h0_0055_5000; fill_pte = 64'h7; fill_level = 2'd0; fill_pte_addr = 56'h0;
        look(16'd8, 39'h00_0001_1234);
        chk("R13", "same-cycle lookup old", 64'(lk_hit), 64'd0);
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        chk("R13", "next-cycle lookup new", 64'(lk_hit), 64'd1);
        chk("R13", "next-cycle paddr", 64'(lk_paddr), 64'h0_0055_5234);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule